// File: doc/BRIEF.md
# Outgoing Write Flush Buffer

This block is a small first-in first-out store for write traffic that is leaving a CPU's memory subsystem toward an external bus. It has three producers. An uncached store pushes one double-word. A data-cache line eviction pushes a two-beat block under a single address. An instruction-cache block write pushes a four-beat block under a single address. Every push arrives in one cycle with all of its beats. It is taken only if enough free slots remain for the whole block, so a block is never split.

The bus side drains one slot per valid/ready handshake. Each slot shows the block address, one 64-bit beat and a flag that marks the first beat of its block, so the bus side can send the address once per block. The block also tracks one outstanding line read. While that read is pending, draining pauses so the read goes out ahead of the buffered write-back, and the producers can keep pushing. If the pipeline asks for external resources while every slot is taken, a stall output is raised and held until the buffer has drained completely.

Top module: `flush_buffer`

## Requirements
- R1: While reset is asserted, and after it is released, the buffer is empty: `level` is 0, `out_valid` is 0, `stall` is 0 and `rd_ready` is 1.
- R2: The slots a push needs depend on `push_kind`: 2'b00 (uncached) needs 1, 2'b01 (data-cache block) needs 2, 2'b10 (instruction-cache block) needs 4, and 2'b11 is reserved and never accepted.
- R3: `push_ready` is high exactly when the kind is not reserved and the free slots (4 − `level`) are at least the slots that kind needs. A refused push changes no state, and `level` never exceeds 4.
- R4: An accepted push of N beats appends N slots in order. Beat i carries `push_data[64*i +: 64]` and `push_addr`, and only beat 0 has `out_first` set. Slots drain in the order they were pushed.
- R5: A slot is removed only in a cycle where `out_valid` and `out_ready` are both high. Until then, `out_addr`, `out_data` and `out_first` hold their values.
- R6: `out_valid` is high exactly when `level` is nonzero and no line read is outstanding.
- R7: A read becomes outstanding in the cycle after `rd_issue` is sampled while `rd_ready` is high. It stays outstanding (`rd_ready` low) until the cycle after `rd_ret` is sampled, and `rd_issue` has no effect while a read is outstanding.
- R8: `stall` rises in the cycle after `ext_req` is sampled with `level` equal to 4. It then stays high until the cycle after `level` is sampled as 0, and it never rises while the buffer is not full.
- R9: A push and a pop may happen in the same cycle. `push_ready` is judged on the occupancy before the pop, and `level` then changes by the slots pushed minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_valid | input | 1 | Producer offers a request |
| push_kind | input | 2 | Request source: 00 uncached, 01 data-cache block, 10 instruction-cache block, 11 reserved |
| push_addr | input | 32 | Address of the write or block |
| push_data | input | 256 | Up to four 64-bit beats, beat i in bits 64*i+63:64*i |
| push_ready | output | 1 | Request fits and is taken when push_valid is high |
| out_valid | output | 1 | Head slot is offered to the bus side |
| out_ready | input | 1 | Bus side takes the head slot |
| out_addr | output | 32 | Address of the head slot's block |
| out_data | output | 64 | Data beat of the head slot |
| out_first | output | 1 | Head slot is the first beat of its block |
| ext_req | input | 1 | Pipeline issues a load or store that needs external resources |
| stall | output | 1 | Pipeline must hold |
| rd_issue | input | 1 | A line read request is sent |
| rd_ret | input | 1 | The outstanding line read has returned |
| rd_ready | output | 1 | No line read is outstanding |
| level | output | 3 | Number of occupied slots |

## Verification
The assertions assume that every input has a known value in every cycle after reset. They also assume that `rd_ret` is raised only while a read is outstanding, because a return with no read pending has no meaning for the tracker. The random stimulus draws `rd_ret` only while the bench's model has a read pending, and it draws `rd_issue` only while no read is pending. Pushes, kinds (including the reserved code), drain readiness and `ext_req` are drawn freely, so refused pushes, simultaneous push and pop, and full-buffer stalls all occur alongside the directed fill-and-drain cases.

// File: rtl/fb_pkg.sv
package fb_pkg;

  typedef enum logic [1:0] {
    SRC_UNCACHED = 2'b00,
    SRC_DBLOCK   = 2'b01,
    SRC_IBLOCK   = 2'b10,
    SRC_RESERVED = 2'b11
  } src_e;

  // Slots a request of the given source occupies; 0 means never accepted.
  function automatic int unsigned slot_cost(src_e src, int unsigned dblk_beats,
                                            int unsigned iblk_beats);
    case (src)
      SRC_UNCACHED: return 1;
      SRC_DBLOCK:   return dblk_beats;
      SRC_IBLOCK:   return iblk_beats;
      default:      return 0;
    endcase
  endfunction

endpackage

// File: rtl/fb_rst_sync.sv
module fb_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/fb_ctrl.sv
module fb_ctrl
  import fb_pkg::*;
#(
  parameter  int DEPTH    = 4,
  parameter  int DC_BEATS = 2,
  localparam int PW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  src_e          push_kind,
  input  logic          out_ready,
  input  logic          rd_busy,
  output logic          push_ready,
  output logic          push_fire,
  output logic          out_valid,
  output logic [CW-1:0] need,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] level
);
  logic [CW-1:0] free_slots;
  logic          pop_fire;
  logic [PW-1:0] wr_ptr_nxt, rd_ptr_nxt;
  logic [CW-1:0] level_nxt;

  always_comb begin
    need       = CW'(slot_cost(push_kind, DC_BEATS, DEPTH));
    free_slots = CW'(DEPTH) - level;
    push_ready = (need != '0) && (free_slots >= need);
    push_fire  = push_valid && push_ready;
    out_valid  = (level != '0) && !rd_busy;
    pop_fire   = out_valid && out_ready;
  end

  // Next-state: pointers wrap naturally because DEPTH is a power of two.
  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    level_nxt  = level;
    if (push_fire) begin
      wr_ptr_nxt = wr_ptr + PW'(need);
      level_nxt  = level_nxt + need;
    end
    if (pop_fire) begin
      rd_ptr_nxt = rd_ptr + PW'(1);
      level_nxt  = level_nxt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      level  <= level_nxt;
    end
  end
endmodule

// File: rtl/fb_slots.sv
module fb_slots #(
  parameter  int DEPTH = 4,
  parameter  int AW    = 32,
  parameter  int DW    = 64,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_fire,
  input  logic [CW-1:0]       need,
  input  logic [PW-1:0]       wr_ptr,
  input  logic [PW-1:0]       rd_ptr,
  input  logic [AW-1:0]       push_addr,
  input  logic [DEPTH*DW-1:0] push_data,
  output logic [AW-1:0]       head_addr,
  output logic [DW-1:0]       head_data,
  output logic                head_first
);
  logic [AW-1:0] addr_q  [DEPTH];
  logic [DW-1:0] data_q  [DEPTH];
  logic          first_q [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic [PW-1:0] beat;
    logic          wr_en;

    always_comb begin
      beat  = PW'(j) - wr_ptr;
      wr_en = push_fire && (CW'(beat) < need);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     first_q[j] <= 1'b0;
      else if (wr_en) first_q[j] <= (beat == '0);
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        addr_q[j] <= push_addr;
        data_q[j] <= push_data[beat*DW +: DW];
      end
    end
  end

  always_comb begin
    head_addr  = addr_q[rd_ptr];
    head_data  = data_q[rd_ptr];
    head_first = first_q[rd_ptr];
  end
endmodule

// File: rtl/fb_stall.sv
module fb_stall #(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] level,
  input  logic          ext_req,
  input  logic          rd_issue,
  input  logic          rd_ret,
  output logic          stall,
  output logic          rd_busy
);
  logic stall_nxt, busy_nxt;

  always_comb begin
    stall_nxt = stall;
    if (level == '0)                              stall_nxt = 1'b0;
    else if (ext_req && (level == CW'(DEPTH)))    stall_nxt = 1'b1;

    busy_nxt = rd_busy;
    if (rd_busy) begin
      if (rd_ret) busy_nxt = 1'b0;
    end else if (rd_issue) begin
      busy_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall   <= 1'b0;
      rd_busy <= 1'b0;
    end else begin
      stall   <= stall_nxt;
      rd_busy <= busy_nxt;
    end
  end
endmodule

// File: rtl/flush_buffer.sv
module flush_buffer
  import fb_pkg::*;
#(
  parameter  int DEPTH    = 4,
  parameter  int DC_BEATS = 2,
  parameter  int AW       = 32,
  parameter  int DW       = 64,
  localparam int PW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_valid,
  input  logic [1:0]          push_kind,
  input  logic [AW-1:0]       push_addr,
  input  logic [DEPTH*DW-1:0] push_data,
  output logic                push_ready,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [AW-1:0]       out_addr,
  output logic [DW-1:0]       out_data,
  output logic                out_first,
  input  logic                ext_req,
  output logic                stall,
  input  logic                rd_issue,
  input  logic                rd_ret,
  output logic                rd_ready,
  output logic [CW-1:0]       level
);
  logic          rst_n_s;
  logic          push_fire;
  logic          rd_busy;
  logic [CW-1:0] need;
  logic [PW-1:0] wr_ptr, rd_ptr;

  fb_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  fb_ctrl #(.DEPTH(DEPTH), .DC_BEATS(DC_BEATS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .push_valid (push_valid),
    .push_kind  (src_e'(push_kind)),
    .out_ready  (out_ready),
    .rd_busy    (rd_busy),
    .push_ready (push_ready),
    .push_fire  (push_fire),
    .out_valid  (out_valid),
    .need       (need),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .level      (level)
  );

  fb_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .push_fire  (push_fire),
    .need       (need),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .push_addr  (push_addr),
    .push_data  (push_data),
    .head_addr  (out_addr),
    .head_data  (out_data),
    .head_first (out_first)
  );

  fb_stall #(.DEPTH(DEPTH)) u_stall (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .level    (level),
    .ext_req  (ext_req),
    .rd_issue (rd_issue),
    .rd_ret   (rd_ret),
    .stall    (stall),
    .rd_busy  (rd_busy)
  );

  assign rd_ready = !rd_busy;
endmodule

// File: rtl/flush_buffer_chk.sv
module flush_buffer_chk #(
  parameter  int DEPTH = 4,
  parameter  int AW    = 32,
  parameter  int DW    = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic [1:0]    push_kind,
  input logic          push_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [DW-1:0] out_data,
  input logic          out_first,
  input logic          stall,
  input logic          rd_ready,
  input logic          rd_ret,
  input logic [CW-1:0] level
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R3
  refused_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (level <= $past(level)));

  // R2
  iblock_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && push_kind == 2'b10) |-> (level == '0));

  // R2
  reserved_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_kind == 2'b11) |-> !push_ready);

  // R5
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      ($stable(out_addr) && $stable(out_data) && $stable(out_first)));

  // R6
  read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready |-> !out_valid);

  // R7
  read_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ready && !rd_ret) |=> !rd_ready);

  // R8
  stall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |=> !stall);

  // R8
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> ($past(level) == CW'(DEPTH)));
endmodule

bind flush_buffer flush_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .push_kind  (push_kind),
  .push_ready (push_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .out_data   (out_data),
  .out_first  (out_first),
  .stall      (stall),
  .rd_ready   (rd_ready),
  .rd_ret     (rd_ret),
  .level      (level)
);

// File: tb/flush_buffer_tb.sv
`timescale 1ns/1ps
module flush_buffer_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         push_valid;
  logic [1:0]   push_kind;
  logic [31:0]  push_addr;
  logic [255:0] push_data;
  logic         push_ready, out_valid, out_ready, out_first;
  logic [31:0]  out_addr;
  logic [63:0]  out_data;
  logic         ext_req, stall, rd_issue, rd_ret, rd_ready;
  logic [2:0]   level;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference model
  logic [31:0] m_addr[$];
  logic [63:0] m_data[$];
  logic        m_first[$];
  bit          m_busy  = 1'b0;
  bit          m_stall = 1'b0;

  always #2.5 clk = ~clk;

  flush_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_kind(push_kind),
    .push_addr(push_addr), .push_data(push_data), .push_ready(push_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .out_first(out_first), .ext_req(ext_req),
    .stall(stall), .rd_issue(rd_issue), .rd_ret(rd_ret),
    .rd_ready(rd_ready), .level(level)
  );

  function automatic int cost(input logic [1:0] k);
    case (k)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit pv, input logic [1:0] k, input bit ordy,
                     input bit ex, input bit iss, input bit ret);
    int  sz, nd;
    bit  e_rdy, e_val, pf, popf, nstall;
    @(negedge clk);
    push_valid = pv; push_kind = k; out_ready = ordy;
    ext_req = ex; rd_issue = iss; rd_ret = ret;
    push_addr = $urandom;
    for (int b = 0; b < 8; b++) push_data[32*b +: 32] = $urandom;
    #1;
    sz    = m_addr.size();
    nd    = cost(k);
    e_rdy = (nd != 0) && ((4 - sz) >= nd);
    e_val = (sz != 0) && !m_busy;
    chk(push_ready == e_rdy, "R3 push_ready", 64'(push_ready), 64'(e_rdy));
    chk(level == 3'(sz), "R9 level", 64'(level), 64'(sz));
    chk(out_valid == e_val, "R6 out_valid", 64'(out_valid), 64'(e_val));
    chk(rd_ready == !m_busy, "R7 rd_ready", 64'(rd_ready), 64'(!m_busy));
    chk(stall == m_stall, "R8 stall", 64'(stall), 64'(m_stall));
    if (sz != 0) begin
      chk(out_addr == m_addr[0], "R4 out_addr", 64'(out_addr), 64'(m_addr[0]));
      chk(out_data == m_data[0], "R4 out_data", out_data, m_data[0]);
      chk(out_first == m_first[0], "R4 out_first", 64'(out_first), 64'(m_first[0]));
    end
    pf   = pv && e_rdy;
    popf = e_val && ordy;
    nstall = m_stall;
    if (sz == 0)             nstall = 1'b0;
    else if (ex && sz == 4)  nstall = 1'b1;
    m_stall = nstall;
    if (m_busy) begin
      if (ret) m_busy = 1'b0;
    end else if (iss) m_busy = 1'b1;
    if (popf) begin
      void'(m_addr.pop_front()); void'(m_data.pop_front()); void'(m_first.pop_front());
    end
    if (pf)
      for (int b = 0; b < nd; b++) begin
        m_addr.push_back(push_addr);
        m_data.push_back(push_data[64*b +: 64]);
        m_first.push_back(b == 0);
      end
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    push_valid = 0; push_kind = 0; push_addr = 0; push_data = '0;
    out_ready = 0; ext_req = 0; rd_issue = 0; rd_ret = 0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state while reset is held
    chk(level == 0 && !out_valid && !stall && rd_ready, "R1 reset state",
        64'({level, out_valid, stall, rd_ready}), 64'b0001);
    rst_n = 1'b1;
    repeat (3) cyc(0, 2'b00, 0, 0, 0, 0);  // R1 after release

    // R2: instruction-cache block fills all four slots, then nothing fits
    cyc(1, 2'b10, 0, 0, 0, 0);
    cyc(1, 2'b00, 0, 0, 0, 0);              // R3 refused when full
    cyc(1, 2'b11, 0, 1, 0, 0);              // R2 reserved kind; R8 stall request
    cyc(0, 2'b00, 0, 0, 0, 0);              // R8 stall visible
    // R6/R7: read pending pauses draining
    cyc(0, 2'b00, 1, 0, 1, 0);
    cyc(0, 2'b00, 1, 0, 0, 0);
    cyc(0, 2'b00, 1, 0, 0, 1);
    repeat (6) cyc(0, 2'b00, 1, 0, 0, 0);   // R5/R4 drain in order, R8 clears
    // R2: two data-cache blocks fill the buffer, third refused
    cyc(1, 2'b01, 0, 0, 0, 0);
    cyc(1, 2'b01, 0, 0, 0, 0);
    cyc(1, 2'b01, 1, 0, 0, 0);              // R9 judged before pop
    repeat (6) cyc(1, 2'b00, 1, 0, 0, 0);   // R9 push and pop together

    for (int i = 0; i < 4000; i++) begin
      bit pv, ordy, ex, iss, ret;
      logic [1:0] k;
      pv   = ($urandom % 10) < 6;
      k    = (($urandom % 10) == 0) ? 2'b11 : 2'($urandom % 3);
      ordy = ($urandom % 2) == 1;
      ex   = ($urandom % 10) < 3;
      iss  = !m_busy && (($urandom % 20) == 0);
      ret  = m_busy && (($urandom % 5) == 0);
      cyc(pv, k, ordy, ex, iss, ret);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule